// File: doc/BRIEF.md
# Reset Exception Sequencer

This block carries out a processor's reset exception in hardware. While the active-low reset input is held low, every bus read and every partly finished step stops at once and is never resumed. The control state takes its defined reset values: the status word, the vector base, the two cache enables, the translation enable and the four transparent-window enables.

After reset is released, the block acts as a simple bus master. It reads two words from the vector table at address zero in supervisor data space. The first word becomes the interrupt stack pointer and the second becomes the program counter. It then fetches four consecutive words starting at the new program counter, in supervisor program space, into a small queue, and raises a done flag. The flag stays high until the next reset.

Each read uses a request/acknowledge handshake. The request and the address hold steady until the cycle in which the acknowledge is high, and that cycle also delivers the read data. Any number of wait cycles is allowed.

Top module: `rst_exc_seq`

## Requirements
- R1: While `rst_n` is low, `bus_req_o` and `done_o` are 0, and `isp_o`, `pc_o` and `pfq_o` are all zero.
- R2: From reset onward, `sr_o` reads 16'h2700. The fields are trace bits at bit 15 and bit 14 (cleared), supervisor at bit 13 (set), master select at bit 12 (cleared), and the interrupt mask at bits 10:8 (7). All other bits are 0.
- R3: From reset onward, `vbr_o` is 32'h0000_0000, and `cache_en_o`, `tc_en_o` and `ttr_en_o` are all 0.
- R4: The first read after release is at address 0 with `bus_space_o` = 2'b01 (supervisor data). Its data loads `isp_o`.
- R5: The second read is at address 4 with `bus_space_o` = 2'b01. Its data loads `pc_o`.
- R6: The next four reads are at PC, PC+4, PC+8 and PC+12, with addresses wrapping modulo 2^32, and use `bus_space_o` = 2'b10 (supervisor program). Read k lands in `pfq_o[32k+31:32k]`.
- R7: While `bus_req_o` is high and `bus_ack_i` is low, the request and the address stay unchanged for any number of wait cycles.
- R8: `done_o` rises in the cycle after the fourth prefetch is acknowledged. It then stays high and no further request is made until reset.
- R9: Pulling reset low in the middle of the sequence drops the request at once and discards the values fetched so far. After release, the sequence starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset request |
| bus_req_o | output | 1 | Read request |
| bus_addr_o | output | 32 | Read byte address |
| bus_space_o | output | 2 | Address space: 01 supervisor data, 10 supervisor program |
| bus_ack_i | input | 1 | Read completes in this cycle |
| bus_rdata_i | input | 32 | Read data, valid with the acknowledge |
| sr_o | output | 16 | Status word |
| vbr_o | output | 32 | Vector base |
| cache_en_o | output | 2 | Instruction/data cache enables |
| tc_en_o | output | 1 | Translation enable |
| ttr_en_o | output | 4 | Transparent-window enables |
| isp_o | output | 32 | Interrupt stack pointer |
| pc_o | output | 32 | Program counter |
| pfq_o | output | 128 | Prefetch queue, entry k at bits 32k+31:32k |
| done_o | output | 1 | Sequence complete |

## Verification
A sequencer stuck in, or skipping, a state becomes visible on the bus within one read. The next address, its space code or the drop of the request will differ from the order 0, 4, PC, PC+4, PC+8, PC+12. A slot loaded from the wrong read shows up as a wrong queue entry or a wrong pointer as soon as `done_o` rises. A state that survives reset shows up the moment reset is applied, as a nonzero pointer or a request that is still live.

// File: rtl/rst_exc_pkg.sv
package rst_exc_pkg;

    localparam int SR_W       = 16;
    localparam int SR_T1_BIT  = 15;
    localparam int SR_T0_BIT  = 14;
    localparam int SR_S_BIT   = 13;
    localparam int SR_M_BIT   = 12;
    localparam int SR_IPL_LSB = 8;
    localparam int SR_IPL_MAX = 7;

    // Only S and the full interrupt mask are set; trace and master bits stay zero.
    localparam logic [SR_W-1:0] SR_RESET =
        (SR_W'(1) << SR_S_BIT) | (SR_W'(SR_IPL_MAX) << SR_IPL_LSB);

    typedef enum logic [2:0] {
        ST_INIT,
        ST_FETCH_SP,
        ST_FETCH_PC,
        ST_PREFETCH,
        ST_DONE
    } seq_st_e;

    typedef enum logic [1:0] {
        SPC_NONE     = 2'd0,
        SPC_SUP_DATA = 2'd1,
        SPC_SUP_PROG = 2'd2
    } bus_spc_e;

endpackage

// File: rtl/rst_exc_ctl.sv
module rst_exc_ctl
    import rst_exc_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_CACHE = 2,
    parameter int N_TTR   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [SR_W-1:0]    sr_o,
    output logic [WORD_W-1:0]  vbr_o,
    output logic [N_CACHE-1:0] cache_en_o,
    output logic               tc_en_o,
    output logic [N_TTR-1:0]   ttr_en_o
);

    typedef struct packed {
        logic [SR_W-1:0]    sr;
        logic [WORD_W-1:0]  vbr;
        logic [N_CACHE-1:0] cen;
        logic               tcen;
        logic [N_TTR-1:0]   tten;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        sr:   SR_RESET,
        vbr:  '0,
        cen:  '0,
        tcen: 1'b0,
        tten: '0
    };

    ctl_t ctl_d, ctl_q;

    // Nothing inside the sequencer writes these; they only take their reset value.
    always_comb begin
        ctl_d = ctl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign sr_o       = ctl_q.sr;
    assign vbr_o      = ctl_q.vbr;
    assign cache_en_o = ctl_q.cen;
    assign tc_en_o    = ctl_q.tcen;
    assign ttr_en_o   = ctl_q.tten;

endmodule

// File: rtl/rst_exc_fsm.sv
module rst_exc_fsm
    import rst_exc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ack_i,
    input  logic [WORD_W-1:0] pc_i,
    output logic              bus_req_o,
    output logic [WORD_W-1:0] bus_addr_o,
    output logic [1:0]        bus_space_o,
    output logic              ld_sp_o,
    output logic              ld_pc_o,
    output logic              ld_q_o,
    output logic [IDX_W-1:0]  q_idx_o,
    output logic              done_o
);

    localparam int BYTES     = WORD_W / 8;
    localparam int STRIDE_SH = $clog2(BYTES);
    localparam logic [WORD_W-1:0] SP_OFS = '0;
    localparam logic [WORD_W-1:0] PC_OFS = WORD_W'(BYTES);
    localparam logic [IDX_W-1:0]  LAST   = IDX_W'(DEPTH - 1);

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        bus_req_o   = 1'b0;
        bus_addr_o  = '0;
        bus_space_o = SPC_NONE;
        ld_sp_o     = 1'b0;
        ld_pc_o     = 1'b0;
        ld_q_o      = 1'b0;
        unique case (fsm_q.st)
            ST_INIT: begin
                fsm_d.st  = ST_FETCH_SP;
                fsm_d.cnt = '0;
            end
            ST_FETCH_SP: begin
                bus_req_o   = 1'b1;
                bus_addr_o  = SP_OFS;
                bus_space_o = SPC_SUP_DATA;
                if (bus_ack_i) begin
                    ld_sp_o  = 1'b1;
                    fsm_d.st = ST_FETCH_PC;
                end
            end
            ST_FETCH_PC: begin
                bus_req_o   = 1'b1;
                bus_addr_o  = PC_OFS;
                bus_space_o = SPC_SUP_DATA;
                if (bus_ack_i) begin
                    ld_pc_o  = 1'b1;
                    fsm_d.st = ST_PREFETCH;
                end
            end
            ST_PREFETCH: begin
                bus_req_o   = 1'b1;
                bus_addr_o  = pc_i + (WORD_W'(fsm_q.cnt) << STRIDE_SH);
                bus_space_o = SPC_SUP_PROG;
                if (bus_ack_i) begin
                    ld_q_o = 1'b1;
                    if (fsm_q.cnt == LAST) fsm_d.st  = ST_DONE;
                    else                   fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_DONE: begin
                fsm_d = fsm_q;
            end
            default: begin
                fsm_d.st = ST_INIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_INIT, cnt: '0};
        else        fsm_q <= fsm_d;
    end

    assign q_idx_o = fsm_q.cnt;
    assign done_o  = (fsm_q.st == ST_DONE);

endmodule

// File: rtl/rst_exc_capt.sv
module rst_exc_capt #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_W-1:0]       rdata_i,
    input  logic                    ld_sp_i,
    input  logic                    ld_pc_i,
    input  logic                    ld_q_i,
    input  logic [IDX_W-1:0]        q_idx_i,
    output logic [WORD_W-1:0]       isp_o,
    output logic [WORD_W-1:0]       pc_o,
    output logic [DEPTH*WORD_W-1:0] pfq_o
);

    typedef struct packed {
        logic [WORD_W-1:0]            sp;
        logic [WORD_W-1:0]            pc;
        logic [DEPTH-1:0][WORD_W-1:0] q;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (ld_sp_i) cap_d.sp = rdata_i;
        if (ld_pc_i) cap_d.pc = rdata_i;
        if (ld_q_i)  cap_d.q[q_idx_i] = rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign isp_o = cap_q.sp;
    assign pc_o  = cap_q.pc;
    assign pfq_o = cap_q.q;

endmodule

// File: rtl/rst_exc_seq.sv
module rst_exc_seq
    import rst_exc_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int DEPTH   = 4,
    parameter int N_CACHE = 2,
    parameter int N_TTR   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    bus_req_o,
    output logic [WORD_W-1:0]       bus_addr_o,
    output logic [1:0]              bus_space_o,
    input  logic                    bus_ack_i,
    input  logic [WORD_W-1:0]       bus_rdata_i,
    output logic [SR_W-1:0]         sr_o,
    output logic [WORD_W-1:0]       vbr_o,
    output logic [N_CACHE-1:0]      cache_en_o,
    output logic                    tc_en_o,
    output logic [N_TTR-1:0]        ttr_en_o,
    output logic [WORD_W-1:0]       isp_o,
    output logic [WORD_W-1:0]       pc_o,
    output logic [DEPTH*WORD_W-1:0] pfq_o,
    output logic                    done_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             ld_sp, ld_pc, ld_q;
    logic [IDX_W-1:0] q_idx;

    rst_exc_ctl #(
        .WORD_W (WORD_W),
        .N_CACHE(N_CACHE),
        .N_TTR  (N_TTR)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sr_o      (sr_o),
        .vbr_o     (vbr_o),
        .cache_en_o(cache_en_o),
        .tc_en_o   (tc_en_o),
        .ttr_en_o  (ttr_en_o)
    );

    rst_exc_fsm #(
        .WORD_W(WORD_W),
        .DEPTH (DEPTH)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_ack_i  (bus_ack_i),
        .pc_i       (pc_o),
        .bus_req_o  (bus_req_o),
        .bus_addr_o (bus_addr_o),
        .bus_space_o(bus_space_o),
        .ld_sp_o    (ld_sp),
        .ld_pc_o    (ld_pc),
        .ld_q_o     (ld_q),
        .q_idx_o    (q_idx),
        .done_o     (done_o)
    );

    rst_exc_capt #(
        .WORD_W(WORD_W),
        .DEPTH (DEPTH)
    ) u_capt (
        .clk    (clk),
        .rst_n  (rst_n),
        .rdata_i(bus_rdata_i),
        .ld_sp_i(ld_sp),
        .ld_pc_i(ld_pc),
        .ld_q_i (ld_q),
        .q_idx_i(q_idx),
        .isp_o  (isp_o),
        .pc_o   (pc_o),
        .pfq_o  (pfq_o)
    );

endmodule

// File: rtl/rst_exc_seq_chk.sv
module rst_exc_seq_chk #(
    parameter int WORD_W = 32,
    parameter int SR_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_o,
    input logic              bus_ack_i,
    input logic [WORD_W-1:0] bus_addr_o,
    input logic [1:0]        bus_space_o,
    input logic              done_o,
    input logic [SR_W-1:0]   sr_o
);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    // R8
    no_req_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o);

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_ack_i));

    // R4
    first_req_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_o) |-> (bus_addr_o == '0 && bus_space_o == 2'd1));

    // R5
    vector_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_space_o == 2'd1) |-> (bus_addr_o[WORD_W-1:3] == '0));

    // R2
    sr_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> (sr_o[13] && !sr_o[12] && sr_o[15:14] == 2'b00 && sr_o[10:8] == 3'd7));

endmodule

bind rst_exc_seq rst_exc_seq_chk #(
    .WORD_W(WORD_W),
    .SR_W  (rst_exc_pkg::SR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req_o  (bus_req_o),
    .bus_ack_i  (bus_ack_i),
    .bus_addr_o (bus_addr_o),
    .bus_space_o(bus_space_o),
    .done_o     (done_o),
    .sr_o       (sr_o)
);

// File: tb/tb_rst_exc_seq.sv
`timescale 1ns/1ps
module tb_rst_exc_seq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req;
    logic [31:0]  bus_addr;
    logic [1:0]   bus_space;
    logic         bus_ack = 1'b0;
    logic [31:0]  bus_rdata = '0;
    logic [15:0]  sr;
    logic [31:0]  vbr;
    logic [1:0]   cache_en;
    logic         tc_en;
    logic [3:0]   ttr_en;
    logic [31:0]  isp, pc;
    logic [127:0] pfq;
    logic         done;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    rst_exc_seq dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req_o(bus_req), .bus_addr_o(bus_addr), .bus_space_o(bus_space),
        .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
        .sr_o(sr), .vbr_o(vbr), .cache_en_o(cache_en), .tc_en_o(tc_en),
        .ttr_en_o(ttr_en), .isp_o(isp), .pc_o(pc), .pfq_o(pfq), .done_o(done)
    );

    // memory image
    logic [31:0] tb_sp, tb_pc;
    int          maxw = 0;
    int          wcnt = 0;
    logic [31:0] log_addr [16];
    logic [1:0]  log_spc  [16];
    int          nlog = 0;

    function automatic logic [31:0] memval(input logic [31:0] a);
        if (a == 32'd0)      return tb_sp;
        else if (a == 32'd4) return tb_pc;
        else                 return a ^ 32'h5A5A_C3C3;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (wcnt == 0) begin
                    bus_ack   = 1'b1;
                    bus_rdata = memval(bus_addr);
                    if (nlog < 16) begin
                        log_addr[nlog] = bus_addr;
                        log_spc[nlog]  = bus_space;
                    end
                    nlog = nlog + 1;
                    wcnt = (maxw == 0) ? 0 : int'($urandom_range(maxw, 0));
                end else begin
                    bus_ack = 1'b0;
                    wcnt    = wcnt - 1;
                end
            end else begin
                bus_ack = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic enter_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
    endtask

    task automatic leave_reset();
        @(posedge clk); #1;
        nlog  = 0;
        wcnt  = (maxw == 0) ? 0 : int'($urandom_range(maxw, 0));
        rst_n = 1'b1;
    endtask

    task automatic check_in_reset();
        check("R1 req in reset", {31'd0, bus_req}, 32'd0);
        check("R1 done in reset", {31'd0, done}, 32'd0);
        check("R1 isp in reset", isp, 32'd0);
        check("R1 pc in reset", pc, 32'd0);
        check("R1 pfq in reset", {31'd0, |pfq}, 32'd0);
        check("R2 sr in reset", {16'd0, sr}, 32'h0000_2700);
        check("R3 vbr in reset", vbr, 32'd0);
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
        check("R8 done reached", {31'd0, seen}, 32'd1);
    endtask

    task automatic check_result();
        check("R2 sr", {16'd0, sr}, 32'h0000_2700);
        check("R3 vbr", vbr, 32'd0);
        check("R3 enables", {25'd0, cache_en, tc_en, ttr_en}, 32'd0);
        check("R4 isp", isp, tb_sp);
        check("R5 pc", pc, tb_pc);
        check("R8 read count", nlog, 32'd6);
        check("R4 addr0", log_addr[0], 32'd0);
        check("R4 space0", {30'd0, log_spc[0]}, 32'd1);
        check("R5 addr1", log_addr[1], 32'd4);
        check("R5 space1", {30'd0, log_spc[1]}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            check("R6 prefetch addr", log_addr[2+k], tb_pc + 32'(4*k));
            check("R6 prefetch space", {30'd0, log_spc[2+k]}, 32'd2);
            check("R6 queue entry", pfq[32*k +: 32], memval(tb_pc + 32'(4*k)));
        end
        check("R7 req low at done", {31'd0, bus_req}, 32'd0);
    endtask

    typedef struct packed {
        logic [31:0] sp;
        logic [31:0] pc;
        logic [3:0]  maxw;
    } scen_t;

    localparam scen_t SCEN [5] = '{
        '{sp: 32'h0000_1000, pc: 32'h0000_0400, maxw: 4'd0},
        '{sp: 32'h8000_FFF0, pc: 32'h0001_2340, maxw: 4'd3},
        '{sp: 32'hFFFF_FFFC, pc: 32'hFFFF_FFF8, maxw: 4'd2},
        '{sp: 32'h0000_0000, pc: 32'h0000_0000, maxw: 4'd7},
        '{sp: 32'h1234_5678, pc: 32'h0ABC_DEF0, maxw: 4'd1}
    };

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // table walk: R4 R5 R6 R7, wrap of PC+8/PC+12 in scenario 2
        for (int s = 0; s < 5; s++) begin
            tb_sp = SCEN[s].sp;
            tb_pc = SCEN[s].pc;
            maxw  = int'(SCEN[s].maxw);
            enter_reset();
            repeat (3) @(negedge clk);
            check_in_reset();
            leave_reset();
            wait_done();
            check_result();
            // R8: done stays, no further reads
            repeat (10) @(negedge clk);
            check("R8 done held", {31'd0, done}, 32'd1);
            check("R8 no extra reads", nlog, 32'd6);
        end

        // R9: abort in mid-sequence, then restart with a new vector
        tb_sp = 32'hAAAA_0000;
        tb_pc = 32'h0000_8000;
        maxw  = 2;
        enter_reset();
        repeat (2) @(negedge clk);
        leave_reset();
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (nlog >= 3) break;
        end
        enter_reset();
        #1;
        check("R9 req dropped", {31'd0, bus_req}, 32'd0);
        check("R9 isp discarded", isp, 32'd0);
        check("R9 pc discarded", pc, 32'd0);
        check("R9 queue discarded", {31'd0, |pfq}, 32'd0);
        check("R9 done low", {31'd0, done}, 32'd0);
        tb_sp = 32'h0BAD_F00C;
        tb_pc = 32'h0000_2220;
        maxw  = 1;
        repeat (2) @(negedge clk);
        leave_reset();
        wait_done();
        check("R9 restart addr", log_addr[0], 32'd0);
        check_result();

        // R9: abort while a read is stalled, before the stack pointer arrives
        maxw = 0;
        enter_reset();
        repeat (2) @(negedge clk);
        maxw = 0;
        @(posedge clk); #1;
        nlog  = 0;
        wcnt  = 6;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 stalled req", {31'd0, bus_req}, 32'd1);
        check("R7 stalled addr", bus_addr, 32'd0);
        enter_reset();
        #1;
        check("R9 stalled abort", {31'd0, bus_req}, 32'd0);
        leave_reset();
        wait_done();
        check_result();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule